// File: doc/BRIEF.md
# Chained-Trigger DMA Channel

This block is one DMA transfer channel. Software sets it up through a small register bus. A 16-bit control word is split across two byte registers. Three further registers hold the source address, the destination address and a transfer count. A source multiplexer watches several request strobes and picks one of them. When the picked strobe fires, a pending flag is raised. While the channel is enabled, each pending request moves one unit over a simple memory bus: one read cycle from the source, then one write cycle to the destination.

The request can come from a software start, from another channel finishing one unit, from another channel finishing its whole run, from a serial receive event, or from one line of an extended group. A 4-bit code in the upper control byte picks the extended line. After each unit, the addresses step by the unit size or stay fixed, and the count decrements. The channel emits a pulse for each unit and a further pulse when the count reaches zero. In normal mode the channel then disables itself. In ring mode it reloads its addresses and count from shadow copies and keeps running.

Top module: `dma_chan`

## Requirements
- R1: After reset, both control bytes and the count, source and destination registers read zero, and `mem_req`, `one_done` and `all_done` are low.
- R2: Low control byte (address 0) layout: bit0 ring, bit1 pending flag, bits3:2 source select, bit4 enable, bit5 byte size, bit6 source increment, bit7 destination increment. A write with bit1 = 0 clears the flag. A write with bit1 = 1 leaves the flag unchanged. Upper control byte (address 1): bits 3:0 always read 0 and ignore writes, and bits 7:4 hold the extended code.
- R3: Source select 0 raises the flag on `sw_start` or `chain_one_done`. Select 1 raises it on `chain_all_done`. Select 2 raises it on `ser_rx_evt`. Strobes that are not selected leave the flag unchanged.
- R4: With select 3, extended code k (0 to 9) raises the flag on `ext_req[k]` only. Codes 10 to 15 never raise it.
- R5: While enable is 0, no memory cycle starts and a pending flag stays set. Setting enable starts the pending transfer.
- R6: An accepted request clears the flag at the same edge. The unit then takes one read cycle at the source address, followed by one write cycle at the destination address that carries the data just read.
- R7: After each unit, an address whose increment bit is 1 advances by 2 in 16-bit size or by 1 in byte size. An address whose increment bit is 0 does not move. `mem_size8` follows the size bit.
- R8: `one_done` is high for exactly one cycle, right after each unit's write cycle, and the count decrements by one. A count of 0 at the start means 2^CW units.
- R9: The unit that brings the count to zero also pulses `all_done` together with `one_done`. In normal mode it clears the enable bit.
- R10: In ring mode, the last unit reloads source, destination and count from the values last written to those registers, and enable stays 1.
- R11: A request that arrives while the flag is already set merges with the pending one and causes no extra unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 ctrl low, 1 ctrl high, 2 source, 3 destination, 4 count |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register (combinational) |
| sw_start | input | 1 | Software start strobe |
| chain_one_done | input | 1 | Other channel finished one unit |
| chain_all_done | input | 1 | Other channel finished all units |
| ser_rx_evt | input | 1 | Serial receive event |
| ext_req | input | EXT_N | Extended request lines |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 write cycle, 0 read cycle |
| mem_size8 | output | 1 | 1 byte unit, 0 16-bit unit |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 16 | Write data (zero-extended byte in byte size) |
| mem_rdata | input | 16 | Read data, valid in the read cycle |
| one_done | output | 1 | One-unit-finished pulse |
| all_done | output | 1 | Count-reached-zero pulse |

## Verification
The bench builds the block with its defaults: AW = 16, CW = 16 and EXT_N = 10. Ten extended lines under a 4-bit code leave codes 10 to 15 without a line, so the bench can drive all ten lines at once and show that those codes still produce no request. A small byte-wide memory lets both unit sizes and both stepping modes be checked against copied bytes. Small counts of 2 and 3 bring the zero-count edge, the normal-mode self-disable and the ring reload within a few units.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;

  // low control byte, MSB first
  typedef struct packed {
    logic       dst_inc;
    logic       src_inc;
    logic       size8;
    logic       en;
    logic [1:0] src_sel;
    logic       flag;
    logic       ring;
  } ctl_lo_t;

  localparam logic [1:0] SEL_SW_CHAIN = 2'd0;
  localparam logic [1:0] SEL_CHAIN_ALL = 2'd1;
  localparam logic [1:0] SEL_SERIAL   = 2'd2;
  localparam logic [1:0] SEL_EXT      = 2'd3;

  localparam logic [2:0] RA_CTL_LO = 3'd0;
  localparam logic [2:0] RA_CTL_HI = 3'd1;
  localparam logic [2:0] RA_SRC    = 3'd2;
  localparam logic [2:0] RA_DST    = 3'd3;
  localparam logic [2:0] RA_CNT    = 3'd4;

  // address step after one unit
  function automatic logic [1:0] step_of(logic size8, logic inc);
    if (!inc) return 2'd0;
    return size8 ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_chan_pkg::*;
#(
  parameter int EXT_N = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [3:0]       ext_sel,
  input  logic             sw_start,
  input  logic             chain_one,
  input  logic             chain_all,
  input  logic             ser_rx,
  input  logic [EXT_N-1:0] ext_req,
  output logic             hit
);
  logic ext_line;

  always_comb begin
    ext_line = 1'b0;
    for (int i = 0; i < EXT_N; i++)
      if (ext_sel == 4'(i)) ext_line = ext_req[i];
  end

  always_comb begin
    unique case (src_sel)
      SEL_SW_CHAIN:  hit = sw_start | chain_one;
      SEL_CHAIN_ALL: hit = chain_all;
      SEL_SERIAL:    hit = ser_rx;
      default:       hit = ext_line;
    endcase
  end

  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SEL_EXT && ext_sel >= 4'(EXT_N)) |-> !hit); // R4
  AST_SERIAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SEL_SERIAL && !ser_rx) |-> !hit); // R3
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wbyte,
  input  logic       req_hit,
  input  logic       accept,
  input  logic       auto_off,
  output ctl_lo_t    ctl,
  output logic [3:0] ext_sel
);
  ctl_lo_t    ctl_q;
  logic [3:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ext_q <= '0;
    end else begin
      if (wr_lo) begin
        ctl_q.ring    <= wbyte[0];
        ctl_q.src_sel <= wbyte[3:2];
        ctl_q.en      <= wbyte[4];
        ctl_q.size8   <= wbyte[5];
        ctl_q.src_inc <= wbyte[6];
        ctl_q.dst_inc <= wbyte[7];
      end
      if (auto_off) ctl_q.en <= 1'b0;
      if (req_hit)
        ctl_q.flag <= 1'b1;
      else if (accept || (wr_lo && !wbyte[1]))
        ctl_q.flag <= 1'b0;
      if (wr_hi) ext_q <= wbyte[7:4];
    end
  end

  assign ctl     = ctl_q;
  assign ext_sel = ext_q;

  AST_FLAG_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && wbyte[1] && !req_hit && !accept) |=> (ctl_q.flag == $past(ctl_q.flag))); // R2
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |=> ctl_q.flag); // R3
endmodule

// File: rtl/dma_xfer_eng.sv
module dma_xfer_eng
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag,
  input  logic          en,
  input  logic          ring,
  input  logic          size8,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wdata,
  input  logic [15:0]   mem_rdata,
  output logic          accept,
  output logic          auto_off,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          one_done,
  output logic          all_done
);
  phase_e        ph;
  logic [15:0]   buf_q;
  logic [AW-1:0] src_q, dst_q, src_sh, dst_sh;
  logic [CW-1:0] cnt_q, cnt_sh;
  logic          last_unit;

  assign accept    = (ph == PH_IDLE) && flag && en;
  assign last_unit = (ph == PH_WR) && (cnt_q == CW'(1));
  assign auto_off  = last_unit && !ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      buf_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      src_sh   <= '0;
      dst_sh   <= '0;
      cnt_sh   <= '0;
      one_done <= 1'b0;
      all_done <= 1'b0;
    end else begin
      one_done <= 1'b0;
      all_done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (accept) ph <= PH_RD;
        PH_RD: begin
          buf_q <= size8 ? {8'h00, mem_rdata[7:0]} : mem_rdata;
          ph    <= PH_WR;
        end
        default: begin
          ph       <= PH_IDLE;
          one_done <= 1'b1;
          all_done <= last_unit;
          if (last_unit && ring) begin
            src_q <= src_sh;
            dst_q <= dst_sh;
            cnt_q <= cnt_sh;
          end else begin
            src_q <= src_q + AW'(step_of(size8, src_inc));
            dst_q <= dst_q + AW'(step_of(size8, dst_inc));
            cnt_q <= cnt_q - CW'(1);
          end
        end
      endcase
      if (wr_src) begin src_q <= wdata;         src_sh <= wdata;         end
      if (wr_dst) begin dst_q <= wdata;         dst_sh <= wdata;         end
      if (wr_cnt) begin cnt_q <= wdata[CW-1:0]; cnt_sh <= wdata[CW-1:0]; end
    end
  end

  assign mem_req   = (ph != PH_IDLE);
  assign mem_we    = (ph == PH_WR);
  assign mem_addr  = (ph == PH_WR) ? dst_q : src_q;
  assign mem_wdata = buf_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign count     = cnt_q;

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RD) |=> (ph == PH_WR)); // R6
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && !en) |=> (ph == PH_IDLE)); // R5
  AST_ONE_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    one_done |=> !one_done); // R8
  AST_ALL_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> one_done); // R9
  AST_RING_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (last_unit && ring && !wr_src && !wr_cnt) |=> (src_q == src_sh && cnt_q == cnt_sh)); // R10
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int EXT_N = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             sw_start,
  input  logic             chain_one_done,
  input  logic             chain_all_done,
  input  logic             ser_rx_evt,
  input  logic [EXT_N-1:0] ext_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_size8,
  output logic [AW-1:0]    mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  output logic             one_done,
  output logic             all_done
);
  localparam int PAD = AW - 8;

  ctl_lo_t       ctl;
  logic [3:0]    ext_sel;
  logic          req_hit, accept, auto_off;
  logic          wr_lo, wr_hi, wr_src, wr_dst, wr_cnt;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] count;

  assign wr_lo  = reg_we && (reg_addr == RA_CTL_LO);
  assign wr_hi  = reg_we && (reg_addr == RA_CTL_HI);
  assign wr_src = reg_we && (reg_addr == RA_SRC);
  assign wr_dst = reg_we && (reg_addr == RA_DST);
  assign wr_cnt = reg_we && (reg_addr == RA_CNT);

  dma_req_sel #(.EXT_N(EXT_N)) u_sel (
    .clk(clk), .rst_n(rst_n), .src_sel(ctl.src_sel), .ext_sel(ext_sel),
    .sw_start(sw_start), .chain_one(chain_one_done), .chain_all(chain_all_done),
    .ser_rx(ser_rx_evt), .ext_req(ext_req), .hit(req_hit)
  );

  dma_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wbyte(reg_wdata[7:0]),
    .req_hit(req_hit), .accept(accept), .auto_off(auto_off),
    .ctl(ctl), .ext_sel(ext_sel)
  );

  dma_xfer_eng #(.AW(AW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .flag(ctl.flag), .en(ctl.en), .ring(ctl.ring),
    .size8(ctl.size8), .src_inc(ctl.src_inc), .dst_inc(ctl.dst_inc),
    .wr_src(wr_src), .wr_dst(wr_dst), .wr_cnt(wr_cnt), .wdata(reg_wdata),
    .mem_rdata(mem_rdata), .accept(accept), .auto_off(auto_off),
    .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .one_done(one_done), .all_done(all_done)
  );

  assign mem_size8 = ctl.size8;

  always_comb begin
    unique case (reg_addr)
      RA_CTL_LO: reg_rdata = {{PAD{1'b0}}, ctl};
      RA_CTL_HI: reg_rdata = {{PAD{1'b0}}, ext_sel, 4'b0000};
      RA_SRC:    reg_rdata = src_addr;
      RA_DST:    reg_rdata = dst_addr;
      RA_CNT:    reg_rdata = AW'(count);
      default:   reg_rdata = '0;
    endcase
  end

  AST_EN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (all_done && !$past(wr_lo)) |-> (ctl.en == ctl.ring)); // R10
endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int EXT_N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic sw_start = 1'b0, chain_one_done = 1'b0, chain_all_done = 1'b0, ser_rx_evt = 1'b0;
  logic [EXT_N-1:0] ext_req = '0;
  logic mem_req, mem_we, mem_size8, one_done, all_done;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  logic [7:0] mem [0:255];
  assign mem_rdata = {mem[8'(mem_addr + 16'd1)], mem[mem_addr[7:0]]};

  dma_chan #(.AW(AW), .CW(CW), .EXT_N(EXT_N)) u_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_start(sw_start),
    .chain_one_done(chain_one_done), .chain_all_done(chain_all_done),
    .ser_rx_evt(ser_rx_evt), .ext_req(ext_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size8(mem_size8), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .one_done(one_done), .all_done(all_done)
  );

  int checks = 0, errors = 0, all_seen = 0;
  bit finished = 0;

  // reference model state
  int m_ph = 0, m_data = 0;
  bit m_ring = 0, m_flag = 0, m_en = 0, m_sz8 = 0, m_sinc = 0, m_dinc = 0;
  int m_sel = 0, m_ext = 0;
  int m_src = 0, m_dst = 0, m_cnt = 0, sh_src = 0, sh_dst = 0, sh_cnt = 0;
  bit m_one = 0, m_all = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_dinc << 7) | (m_sinc << 6) | (m_sz8 << 5) | (m_en << 4) |
                (m_sel << 2) | (m_flag << 1) | m_ring;
      1: return m_ext << 4;
      2: return m_src;
      3: return m_dst;
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit hit, acc, last, dis, clr;
    int n_ph, stp;
    int w;
    w = int'(reg_wdata);
    hit = 0; dis = 0; clr = 0; last = 0;
    case (m_sel)
      0: hit = sw_start || chain_one_done;
      1: hit = chain_all_done;
      2: hit = ser_rx_evt;
      default: if (m_ext < EXT_N) hit = ext_req[m_ext];
    endcase
    acc = (m_ph == 0) && m_flag && m_en;
    n_ph = m_ph; m_one = 0; m_all = 0;
    if (m_ph == 0) begin
      if (acc) n_ph = 1;
    end else if (m_ph == 1) begin
      m_data = m_sz8 ? int'(mem[m_src & 255])
                     : (int'(mem[(m_src + 1) & 255]) << 8) | int'(mem[m_src & 255]);
      n_ph = 2;
    end else begin
      mem[m_dst & 255] = m_data[7:0];
      if (!m_sz8) mem[(m_dst + 1) & 255] = m_data[15:8];
      n_ph = 0; m_one = 1;
      last = (m_cnt == 1); m_all = last;
      stp = m_sz8 ? 1 : 2;
      if (last && m_ring) begin
        m_src = sh_src; m_dst = sh_dst; m_cnt = sh_cnt;
      end else begin
        if (m_sinc) m_src = (m_src + stp) & 16'hFFFF;
        if (m_dinc) m_dst = (m_dst + stp) & 16'hFFFF;
        m_cnt = (m_cnt - 1) & 16'hFFFF;
      end
      dis = last && !m_ring;
    end
    if (reg_we) begin
      case (int'(reg_addr))
        0: begin
          m_ring = w[0]; m_sel = (w >> 2) & 3; m_en = w[4];
          m_sz8 = w[5]; m_sinc = w[6]; m_dinc = w[7]; clr = !w[1];
        end
        1: m_ext = (w >> 4) & 15;
        2: begin m_src = w & 16'hFFFF; sh_src = m_src; end
        3: begin m_dst = w & 16'hFFFF; sh_dst = m_dst; end
        4: begin m_cnt = w & 16'hFFFF; sh_cnt = m_cnt; end
        default: ;
      endcase
    end
    if (dis) m_en = 0;
    if (hit) m_flag = 1;
    else if (acc || clr) m_flag = 0;
    m_ph = n_ph;
  endtask

  always @(posedge clk) if (rst_n) model_step();

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 mem_req", int'(mem_req), int'(m_ph != 0));
      chk("R6 mem_we", int'(mem_we), int'(m_ph == 2));
      if (m_ph != 0) chk("R7 mem_addr", int'(mem_addr), (m_ph == 2) ? m_dst : m_src);
      if (m_ph != 0) chk("R7 mem_size8", int'(mem_size8), int'(m_sz8));
      if (m_ph == 2) chk("R6 mem_wdata", int'(mem_wdata), m_data & (m_sz8 ? 255 : 65535));
      chk("R8 one_done", int'(one_done), int'(m_one));
      chk("R9 all_done", int'(all_done), int'(m_all));
      chk("R2 reg_rdata", int'(reg_rdata), exp_rd(int'(reg_addr)));
      if (all_done) all_seen++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = AW'(d);
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_check(int a, int exp, string tag);
    @(negedge clk); #1;
    reg_addr = 3'(a);
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  // kind: 0 sw, 1 chain one, 2 chain all, 3 serial, 4 one ext line, 5 all ext lines
  task automatic pulse(int kind, int idx);
    @(negedge clk); #1;
    case (kind)
      0: sw_start = 1'b1;
      1: chain_one_done = 1'b1;
      2: chain_all_done = 1'b1;
      3: ser_rx_evt = 1'b1;
      4: ext_req[idx] = 1'b1;
      default: ext_req = '1;
    endcase
    @(negedge clk); #1;
    sw_start = 1'b0; chain_one_done = 1'b0; chain_all_done = 1'b0;
    ser_rx_evt = 1'b0; ext_req = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    idle(3); #1;
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_check(a, 0, "R1 reset readback");
    chk("R1 mem_req after reset", int'(mem_req), 0);
    // R2 upper byte: low nibble reads zero
    wr(1, 'hFF);
    rd_check(1, 'hF0, "R2 upper byte low nibble");
    wr(1, 'h00);
    // R5 disabled: flag pends, no traffic
    wr(2, 'h10); wr(3, 'h80); wr(4, 2);
    wr(0, 'h00);
    pulse(0, 0); idle(4);
    rd_check(0, 'h02, "R5 flag pends while disabled");
    chk("R5 no memory cycle", int'(mem_req), 0);
    wr(0, 'h02);
    rd_check(0, 'h02, "R2 write one keeps flag");
    wr(0, 'h00);
    rd_check(0, 'h00, "R2 write zero clears flag");
    // R3 source encodings
    pulse(1, 0); idle(1);
    rd_check(0, 'h02, "R3 select 0 chain one");
    wr(0, 'h00);
    pulse(3, 0); idle(1);
    rd_check(0, 'h00, "R3 select 0 ignores serial");
    wr(0, 'h04);
    pulse(2, 0); idle(1);
    rd_check(0, 'h06, "R3 select 1 chain all");
    wr(0, 'h04);
    wr(0, 'h08);
    pulse(0, 0); idle(1);
    rd_check(0, 'h08, "R3 select 2 ignores software start");
    pulse(3, 0); idle(1);
    rd_check(0, 'h0A, "R3 select 2 serial");
    // R4 extended codes, including the ones without a line
    wr(0, 'h0C);
    for (int code = 0; code < 16; code++) begin
      wr(1, code << 4);
      pulse(5, 0); idle(1);
      rd_check(0, (code < EXT_N) ? 'h0E : 'h0C, "R4 extended code");
      wr(0, 'h0C);
    end
    wr(1, 3 << 4);
    pulse(4, 5); idle(1);
    rd_check(0, 'h0C, "R4 other line ignored");
    pulse(4, 3); idle(1);
    rd_check(0, 'h0E, "R4 matching line");
    wr(0, 'h0C);
    // R6 R7 R8 R9 16-bit, both increment, normal mode
    wr(0, 'hD0);
    pulse(0, 0); idle(6);
    rd_check(4, 1, "R8 count after one unit");
    pulse(0, 0); idle(6);
    rd_check(0, 'hC0, "R9 enable cleared at zero");
    rd_check(2, 'h14, "R7 source step 2");
    rd_check(3, 'h84, "R7 destination step 2");
    rd_check(4, 0, "R8 count zero");
    chk("R9 one all_done pulse", all_seen, 1);
    for (int i = 0; i < 4; i++) chk("R6 copied bytes", int'(mem['h80 + i]), int'(mem['h10 + i]));
    // R11 merge, R7 byte step, fixed destination
    wr(2, 'h20); wr(3, 'h90); wr(4, 3);
    wr(0, 'h60);
    pulse(0, 0); idle(2); pulse(0, 0); idle(1);
    rd_check(0, 'h62, "R5 pending while disabled");
    wr(0, 'h72); idle(10);
    rd_check(4, 2, "R11 merged requests give one unit");
    rd_check(2, 'h21, "R7 byte step");
    rd_check(3, 'h90, "R7 fixed destination");
    rd_check(0, 'h70, "R6 flag cleared on accept");
    chk("R6 byte copy", int'(mem['h90]), int'(mem['h20]));
    // R10 ring mode
    all_seen = 0;
    wr(2, 'h30); wr(3, 'hA0); wr(4, 2);
    wr(0, 'hD1);
    pulse(0, 0); idle(6);
    pulse(0, 0); idle(6);
    rd_check(2, 'h30, "R10 source reloaded");
    rd_check(3, 'hA0, "R10 destination reloaded");
    rd_check(4, 2, "R10 count reloaded");
    rd_check(0, 'hD1, "R10 stays enabled");
    chk("R10 all_done once", all_seen, 1);
    pulse(0, 0); idle(6);
    rd_check(2, 'h32, "R10 runs after wrap");
    rd_check(4, 1, "R10 count after wrap");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule